// File: doc/BRIEF.md
# MII Management Command Engine

This block runs clause-22 management transactions toward an Ethernet PHY from a single command register. Software, or a neighbouring controller, first loads the 16-bit write-data register if it needs one. It then writes the command register with a PHY address, a register address and one request bit, either read or write. The engine builds a 64-bit serial frame and shifts it out on the management clock and data pins. It releases the data pin whenever the PHY is the one that should drive it.

The request bit acts as the busy flag. It stays set for the whole frame and clears itself in the cycle the frame ends. When a read completes, the 16 bits sampled from the PHY are written into the low half of the same command register, so a caller polls one location for both completion and result. The management clock is the system clock divided by a parameter. It is held low whenever no frame is running.

Top module: `mii_mgmt_engine`

## Requirements
- R1: After reset the command register reads zero, `mdc` is low and `mdio_oe` is low, so the data pin is released.
- R2: Command register layout: bits [15:0] hold data or read result, [20:16] the PHY address (0 to 31), [25:21] the register address, bit 26 the read request and bit 27 the write request. Bits [31:28] always read zero. A command write with neither request bit set stores the fields and starts no frame.
- R3: A command with a request bit set starts a frame. That request bit reads one for the whole frame and returns to zero just after the 64th rising edge of `mdc`, at the falling edge that follows it.
- R4: The first 46 frame bits, MSB first, are: 32 ones, start bits 0 then 1, an opcode (1,0 for read; 0,1 for write), the 5-bit PHY address and the 5-bit register address. Each bit is held stable across the `mdc` rising edge.
- R5: In a write frame the engine drives the turnaround bits 1 then 0, followed by the 16 bits of the write-data register, MSB first. `mdio_oe` stays high for all 64 bits.
- R6: In a read frame `mdio_oe` is low from the turnaround (bit 46) to the end of the frame. The 16 values of `mdio_i` sampled at `mdc` rising edges 49 to 64 are placed MSB first in command bits [15:0] when the frame ends.
- R7: The `mdc` period is 2*HALF_DIV system clocks while a frame runs, and `mdc` is low whenever no request bit is set.
- R8: A command write that arrives while a frame is in progress is ignored. The register fields do not change, and the running frame and its result are unaffected.
- R9: If both request bits are written as one, a read frame is performed, and both bits clear when it ends.
- R10: All 32 PHY addresses are carried correctly in both read and write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Value written to the command register |
| dat_wr | input | 1 | Write strobe for the write-data register |
| dat_wdata | input | 16 | Value for the write-data register |
| cmd_rdata | output | 32 | Current command register content |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | Management data sampled from the pin |
| mdio_o | output | 1 | Management data driven to the pin |
| mdio_oe | output | 1 | Output enable for the data pin |

## Verification
The hardest situation to create is a second command landing in the middle of a running frame. Both the register contents and the shape of the frame already on the wire have to survive it. The bench starts a read, waits a few dozen clocks until the frame is deep in its preamble, then writes a conflicting write command. It checks the fields at once and the captured frame afterwards, and then confirms that no second frame follows. A PHY model in the bench records every bit at the `mdc` rising edges and answers reads with a value computed from the address pair. The bench sweeps all 32 PHY addresses for both reads and writes.

// File: rtl/mme_pkg.sv
package mme_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int CMD_W      = 32;
  localparam int PHY_LSB    = 16;
  localparam int REG_LSB    = 21;
  localparam int RD_BIT     = 26;
  localparam int WR_BIT     = 27;
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam logic [CMD_W-1:0] CMD_MASK = 32'h0FFF_FFFF;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mgmt_opc_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg,
    input logic [DATA_W-1:0] wd
  );
    mgmt_opc_e opc;
    opc = rd ? OPC_READ : OPC_WRITE;
    build_frame = {32'hFFFF_FFFF, 2'b01, opc, phy, rg,
                   (rd ? 2'b11 : 2'b10), (rd ? 16'h0000 : wd)};
  endfunction
endpackage

// File: rtl/mme_mdc_div.sv
module mme_mdc_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          term;

  assign term = (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      cnt_d = term ? '0 : cnt_q + 1'b1;
      mdc_d = term ? ~mdc_q : mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = run & term & ~mdc_q;
  assign fall_tick = run & term & mdc_q;
endmodule

// File: rtl/mme_frame_seq.sv
module mme_frame_seq
  import mme_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] start_phy,
  input  logic [ADDR_W-1:0] start_reg,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              op_rd,
  output logic              done,
  output logic [IDX_W-1:0]  bit_idx,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic [DATA_W-1:0]     rdata_q, rdata_d;
  logic                  last;

  assign last = (idx_q == IDX_W'(FRAME_BITS - 1));
  assign done = busy_q & fall_tick & last;

  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    rdata_d = rdata_q;
    if (start) begin
      busy_d  = 1'b1;
      rd_d    = start_rd;
      idx_d   = '0;
      shift_d = build_frame(start_rd, start_phy, start_reg, start_wdata);
      rdata_d = '0;
    end else if (busy_q) begin
      if (rise_tick && rd_q && (idx_q >= IDX_W'(DATA_IDX)))
        rdata_d = {rdata_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (last) begin
          busy_d = 1'b0;
        end else begin
          idx_d   = idx_q + 1'b1;
          shift_d = {shift_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      shift_q <= '0;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      rd_q    <= rd_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      rdata_q <= rdata_d;
    end
  end

  assign busy    = busy_q;
  assign op_rd   = rd_q;
  assign bit_idx = idx_q;
  assign rdata   = rdata_q;
  assign mdio_o  = shift_q[FRAME_BITS-1];
  assign mdio_oe = busy_q & ~(rd_q & (idx_q >= IDX_W'(TA_IDX)));
endmodule

// File: rtl/mii_mgmt_engine.sv
module mii_mgmt_engine
  import mme_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        dat_wr,
  input  logic [15:0] dat_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DATA_W-1:0] dat_q;
  logic              cmd_en;
  logic              busy, op_rd, done, start;
  logic              rise_tick, fall_tick;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] rdata;
  logic              go_rd, go_wr;

  assign go_rd  = cmd_wdata[RD_BIT];
  assign go_wr  = cmd_wdata[WR_BIT];
  assign start  = cmd_wr & ~busy & (go_rd | go_wr);
  assign cmd_en = done | (cmd_wr & ~busy);

  always_comb begin
    cmd_d = cmd_q;
    if (done) begin
      cmd_d[RD_BIT] = 1'b0;
      cmd_d[WR_BIT] = 1'b0;
      if (op_rd) cmd_d[DATA_W-1:0] = rdata;
    end else if (cmd_wr && !busy) begin
      cmd_d = cmd_wdata & CMD_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_wr) dat_q <= dat_wdata;
  end

  mme_mdc_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mme_frame_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_rd    (go_rd),
    .start_phy   (cmd_wdata[PHY_LSB +: ADDR_W]),
    .start_reg   (cmd_wdata[REG_LSB +: ADDR_W]),
    .start_wdata (dat_q),
    .rise_tick   (rise_tick),
    .fall_tick   (fall_tick),
    .mdio_i      (mdio_i),
    .busy        (busy),
    .op_rd       (op_rd),
    .done        (done),
    .bit_idx     (bit_idx),
    .rdata       (rdata),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
  );

  assign cmd_rdata = cmd_q;
endmodule

// File: rtl/mme_checker.sv
module mme_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [31:0] cmd_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        op_rd
);
  logic       mdc_q;
  logic [6:0] rises_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q   <= 1'b0;
      rises_q <= '0;
    end else begin
      mdc_q <= mdc;
      if (!busy)              rises_q <= '0;
      else if (mdc && !mdc_q) rises_q <= rises_q + 1'b1;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R1
  AST_GO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cmd_rdata[27:26] != 2'b00)); // R3
  AST_RISE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rises_q <= 7'd64)); // R3
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_rd) |-> mdio_oe); // R5
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_rd && rises_q >= 7'd47) |-> !mdio_oe); // R6
  AST_MDC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdata[27:26] == 2'b00) |-> !mdc); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_rdata[25:16])); // R8
endmodule

bind mii_mgmt_engine mme_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .cmd_rdata (cmd_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .busy      (busy),
  .op_rd     (op_rd)
);

// File: tb/mii_mgmt_engine_bench.sv
module mii_mgmt_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic        clk, rst_n;
  logic        cmd_wr, dat_wr;
  logic [31:0] cmd_wdata, cmd_rdata;
  logic [15:0] dat_wdata;
  logic        mdc, mdio_i, mdio_o, mdio_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  mii_mgmt_engine #(.HALF_DIV(HALF)) u_mii_mgmt_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .cmd_rdata(cmd_rdata),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model: records each bit at the MDC rising edge and answers reads
  logic        phy_clr = 1'b0;
  logic        phy_rd  = 1'b0;
  logic [15:0] phy_val = 16'h0;
  int          rise_cnt;
  int          last_rise;
  int          per;
  logic [63:0] cap_v, cap_oe;

  always @(posedge mdc or posedge phy_clr) begin
    if (phy_clr) begin
      rise_cnt <= 0; cap_v <= '0; cap_oe <= '0; per <= 0;
    end else begin
      if (rise_cnt < 64) begin
        cap_v[63-rise_cnt]  <= mdio_o;
        cap_oe[63-rise_cnt] <= mdio_oe;
      end
      if (rise_cnt == 1) per <= cyc - last_rise;
      last_rise <= cyc;
      rise_cnt  <= rise_cnt + 1;
    end
  end

  assign mdio_i = (phy_rd && rise_cnt >= 48 && rise_cnt < 64) ? phy_val[63-rise_cnt] : 1'b1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] phy_answer(input int phy, input int rg);
    int v;
    v = ((phy * 16'h0841) + (rg * 16'h1357)) ^ 16'hA5C3;
    return v[15:0];
  endfunction

  function automatic logic [63:0] exp_frame(input bit rd, input int phy, input int rg, input logic [15:0] wd);
    logic [4:0] p, r;
    p = phy[4:0]; r = rg[4:0];
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
            (rd ? 2'b11 : 2'b10), (rd ? 16'h0 : wd)};
  endfunction

  task automatic put_cmd(input logic [31:0] v);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic put_dat(input logic [15:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 5000 && cmd_rdata[27:26] != 2'b00; t++) @(negedge clk);
  endtask

  task automatic start_frame(input bit rd, input bit both, input int phy, input int rg, input logic [15:0] wd);
    logic [31:0] c;
    @(negedge clk); phy_clr = 1'b1; #1 phy_clr = 1'b0;
    phy_rd  = rd;
    phy_val = phy_answer(phy, rg);
    if (!rd) put_dat(wd);
    c = {4'b0, (both | !rd), rd, rg[4:0], phy[4:0], 16'h0};
    put_cmd(c);
    check(cmd_rdata[27:26] == c[27:26], "R3 request bit set during frame", cmd_rdata, c);
  endtask

  task automatic finish_frame(input bit rd, input int phy, input int rg, input logic [15:0] wd, input bit chk_per);
    logic [63:0] ef;
    logic [31:0] ec;
    ef = exp_frame(rd, phy, rg, wd);
    wait_idle();
    check(rise_cnt == 64, "R3 request clears after 64 MDC rises", rise_cnt, 64);
    check(mdc == 1'b0, "R7 MDC low after frame", mdc, 0);
    if (rd) begin
      check(cap_v[63:18] == ef[63:18], "R4 R10 read frame header", cap_v, ef);
      check(cap_oe == {{46{1'b1}}, 18'h0}, "R6 pin released from turnaround", cap_oe, {{46{1'b1}}, 18'h0});
      ec = {6'b0, rg[4:0], phy[4:0], phy_answer(phy, rg)};
      check(cmd_rdata == ec, "R6 R2 read result in low half", cmd_rdata, ec);
    end else begin
      check(cap_v == ef, "R5 R10 write frame bits", cap_v, ef);
      check(cap_oe == '1, "R5 pin driven for whole write", cap_oe, '1);
      ec = {6'b0, rg[4:0], phy[4:0], 16'h0};
      check(cmd_rdata == ec, "R2 fields after write", cmd_rdata, ec);
    end
    if (chk_per) check(per == 2 * HALF, "R7 MDC period", per, 2 * HALF);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; dat_wr = 1'b0; cmd_wdata = '0; dat_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_rdata == 32'h0, "R1 reset command register", cmd_rdata, 0);
    check(mdc == 1'b0, "R1 reset MDC low", mdc, 0);
    check(mdio_oe == 1'b0, "R1 reset pin released", mdio_oe, 0);

    // R2: command without request bits stores fields, masks top bits, no frame
    @(negedge clk); phy_clr = 1'b1; #1 phy_clr = 1'b0;
    put_cmd(32'hF000_0000 | (32'd17 << 21) | (32'd9 << 16) | 32'hBEEF);
    repeat (40) @(negedge clk);
    check(cmd_rdata == ((32'd17 << 21) | (32'd9 << 16) | 32'hBEEF), "R2 field store and mask",
          cmd_rdata, (32'd17 << 21) | (32'd9 << 16) | 32'hBEEF);
    check(rise_cnt == 0 && mdc == 1'b0, "R2 no frame without request", rise_cnt, 0);

    // R10 sweep: every PHY address, read then write
    for (int p = 0; p < 32; p++) begin
      int rg;
      logic [15:0] wd;
      rg = (p * 7 + 3) % 32;
      start_frame(1'b1, 1'b0, p, rg, 16'h0);
      finish_frame(1'b1, p, rg, 16'h0, p == 0);
      rg = p ^ 31;
      wd = 16'(p * 16'h0F1D + 16'h8421);
      start_frame(1'b0, 1'b0, p, rg, wd);
      finish_frame(1'b0, p, rg, wd, p == 1);
    end

    // R9: both request bits -> read frame, both clear
    start_frame(1'b1, 1'b1, 22, 13, 16'h0);
    finish_frame(1'b1, 22, 13, 16'h0, 1'b0);
    check(cap_v[29:28] == 2'b10, "R9 read opcode chosen", cap_v[29:28], 2'b10);
    check(cmd_rdata[27:26] == 2'b00, "R9 both request bits clear", cmd_rdata[27:26], 0);

    // R8: command while busy is ignored
    start_frame(1'b1, 1'b0, 5, 12, 16'h0);
    repeat (40) @(negedge clk);
    put_cmd({4'b0, 1'b1, 1'b0, 5'd1, 5'd20, 16'h1234});
    check(cmd_rdata[25:16] == {5'd12, 5'd5}, "R8 fields kept while busy",
          cmd_rdata[25:16], {5'd12, 5'd5});
    finish_frame(1'b1, 5, 12, 16'h0, 1'b0);
    repeat (100) @(negedge clk);
    check(rise_cnt == 64 && cmd_rdata[27:26] == 2'b00, "R8 no frame from ignored command",
          rise_cnt, 64);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule